// File: doc/BRIEF.md
# Reference Switch Event Log

This block keeps a history of clock-reference selector decisions so that timing faults seen in the field can be traced back to their cause. Whenever the selector moves between reference A, reference B and holdover, it pulses a strobe. On that strobe the block captures one record into an on-chip circular store. The record holds the free-running timestamp, the state just entered, the reason for the move, the three selector timers as they stood at that instant, the quality level of the chosen input and the temperature read near the oscillator.

A reader drains the records oldest first through a show-ahead read port. The current fill level and a watermark flag are visible at all times. If the reader falls behind, the newest record replaces the oldest one and a sticky overflow flag records the loss.

Alongside the store, a rate monitor counts strobes in fixed back-to-back windows. It raises an alarm when one window holds more switches than the allowed limit, which is the signature of a flapping selector.

Top module: `sel_event_log`

## Requirements
- R1: After reset the store is empty. This means `rd_valid`=0 and `fill_level`=0. `overflow`, `wm_hit` and `rate_alarm` are all 0.
- R2: A cycle with `sw_strobe`=1 stores exactly one record, and `fill_level` rises by one at the next clock edge. The record carries `ts_in` and `sw_state` from the strobe cycle. State codes are A=0, B=1 and holdover=2. The record also carries `sw_reason`, coded as loss of signal=0, invalid=1, quality drop=2 and timeout=3.
- R3: The record holds the eligibility, hold-off and cooldown timer values present in the strobe cycle. Later changes on those inputs do not alter it.
- R4: The record holds the quality level and temperature present in the strobe cycle.
- R5: Records are read oldest first. While `rd_valid`=1, the `rd_*` outputs show the oldest record, and `rd_en`=1 removes it at the clock edge. `rd_en` on an empty store is ignored: it changes no state and does not disturb later records.
- R6: The store holds 32 records. A strobe with the store full and no read overwrites the oldest record. `fill_level` stays at 32, `overflow` becomes 1, and the next record read is the second oldest.
- R7: A strobe and a read in the same cycle lose no record. On a non-empty store, the head is removed, the new record is appended and `fill_level` is unchanged. On an empty store, the new record is stored and `fill_level` becomes 1.
- R8: `wm_hit` is 1 exactly when `fill_level` is at least 24.
- R9: Strobes are counted in fixed windows of 256 cycles. The first window starts at reset release. The alarm rises in the cycle after the strobe that makes one window's count exceed 3. It stays high to the end of that window and clears at the window boundary, where the count restarts from zero.
- R10: `overflow` stays 1 after being set, including across reads, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_strobe | input | 1 | Selector transition pulse |
| sw_state | input | 2 | State entered: 0 A, 1 B, 2 holdover |
| sw_reason | input | 2 | Reason: 0 LOS, 1 invalid, 2 quality drop, 3 timeout |
| tmr_elig | input | 16 | Eligibility timer snapshot |
| tmr_holdoff | input | 16 | Hold-off timer snapshot |
| tmr_cool | input | 16 | Cooldown timer snapshot |
| ql_in | input | 4 | Quality level of selected input |
| temp_in | input | 12 | Temperature near the oscillator |
| ts_in | input | 32 | Free-running timestamp |
| rd_en | input | 1 | Remove the head record |
| rd_valid | output | 1 | Store holds at least one record |
| rd_ts | output | 32 | Head record timestamp |
| rd_state | output | 2 | Head record state |
| rd_reason | output | 2 | Head record reason |
| rd_elig | output | 16 | Head record eligibility timer |
| rd_holdoff | output | 16 | Head record hold-off timer |
| rd_cool | output | 16 | Head record cooldown timer |
| rd_ql | output | 4 | Head record quality level |
| rd_temp | output | 12 | Head record temperature |
| fill_level | output | 6 | Number of stored records |
| wm_hit | output | 1 | Fill at or above watermark |
| overflow | output | 1 | Sticky record-loss flag |
| rate_alarm | output | 1 | Switch-rate limit exceeded in current window |

## Verification
The bench targets the full-store cases. It checks a plain overwrite, and it checks a strobe combined with a read while full. A design that moved only the write pointer would hand back the overwritten record, and one that counted the overwrite as growth would report 33. A strobe that arrives together with a read on an empty store must still be kept: a design that honoured the read first would drop the record or underflow the count. The watermark is probed at fills of 23 and 24, where an off-by-one boundary shows up. The rate alarm is checked on the fourth strobe of a window, held mid-window, cleared at the boundary, and left quiet by three strobes in the next window. A monitor that never reset its count would raise the alarm again there.

// File: rtl/sel_event_log_pkg.sv
package sel_event_log_pkg;

    typedef enum logic [1:0] {
        SEL_REF_A   = 2'd0,
        SEL_REF_B   = 2'd1,
        SEL_HOLD    = 2'd2
    } sel_state_e;

    typedef enum logic [1:0] {
        WHY_LOS     = 2'd0,
        WHY_INVALID = 2'd1,
        WHY_QL_DROP = 2'd2,
        WHY_TIMEOUT = 2'd3
    } sel_reason_e;

endpackage

// File: rtl/sel_event_log_ring.sv
module sel_event_log_ring #(
    parameter int DEPTH    = 32,
    parameter int W        = 8,
    parameter int WM_LEVEL = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic                         rd_valid,
    output logic [W-1:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         wm_hit,
    output logic                         overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovf;
    } ring_s;

    ring_s       r_q, r_d;
    logic [W-1:0] mem_q [DEPTH];
    logic        empty, full, pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (r_q.cnt == '0);
    assign full  = (r_q.cnt == CW'(DEPTH));
    assign pop   = rd_en && !empty;

    always_comb begin
        r_d = r_q;
        if (wr_en && full && !pop) begin
            // overwrite oldest: both pointers advance, count holds
            r_d.wr  = bump(r_q.wr);
            r_d.rd  = bump(r_q.rd);
            r_d.ovf = 1'b1;
        end else begin
            if (wr_en) r_d.wr = bump(r_q.wr);
            if (pop)   r_d.rd = bump(r_q.rd);
            if (wr_en && !pop)      r_d.cnt = r_q.cnt + 1'b1;
            else if (!wr_en && pop) r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[r_q.wr] <= wr_data;
    end

    assign rd_valid = !empty;
    assign rd_data  = mem_q[r_q.rd];
    assign fill     = r_q.cnt;
    assign wm_hit   = (r_q.cnt >= CW'(WM_LEVEL));
    assign overflow = r_q.ovf;

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(DEPTH));
    p_full_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && r_q.ovf));
    p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !empty) |=> $stable(r_q.cnt));
    p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ovf |=> r_q.ovf);
endmodule

// File: rtl/sel_event_log_rate.sv
module sel_event_log_rate #(
    parameter int WINDOW_CYC = 256,
    parameter int RATE_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic alarm
);
    localparam int WW = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
    localparam int NW = $clog2(RATE_LIMIT + 2);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [NW-1:0] cnt;
        logic          alarm;
    } rate_s;

    rate_s         s_q, s_d;
    logic          wrap;
    logic [NW-1:0] base;

    assign wrap = (s_q.win == WW'(WINDOW_CYC - 1));

    always_comb begin
        s_d     = s_q;
        s_d.win = wrap ? '0 : s_q.win + 1'b1;
        base    = wrap ? '0 : s_q.cnt;
        // saturate one past the limit
        s_d.cnt = (strobe && base <= NW'(RATE_LIMIT)) ? base + 1'b1 : base;
        s_d.alarm = (wrap ? 1'b0 : s_q.alarm) || (s_d.cnt > NW'(RATE_LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alarm = s_q.alarm;

    p_alarm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.alarm && !wrap) |=> s_q.alarm);
    p_window_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !strobe) |=> (!s_q.alarm && s_q.cnt == '0));
    p_alarm_needs_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.alarm && !strobe) |=> !s_q.alarm);
endmodule

// File: rtl/sel_event_log.sv
module sel_event_log
    import sel_event_log_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int WM_LEVEL   = 24,
    parameter int TS_W       = 32,
    parameter int TMR_W      = 16,
    parameter int QL_W       = 4,
    parameter int TEMP_W     = 12,
    parameter int WINDOW_CYC = 256,
    parameter int RATE_LIMIT = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sw_strobe,
    input  logic [1:0]                  sw_state,
    input  logic [1:0]                  sw_reason,
    input  logic [TMR_W-1:0]            tmr_elig,
    input  logic [TMR_W-1:0]            tmr_holdoff,
    input  logic [TMR_W-1:0]            tmr_cool,
    input  logic [QL_W-1:0]             ql_in,
    input  logic [TEMP_W-1:0]           temp_in,
    input  logic [TS_W-1:0]             ts_in,
    input  logic                        rd_en,
    output logic                        rd_valid,
    output logic [TS_W-1:0]             rd_ts,
    output logic [1:0]                  rd_state,
    output logic [1:0]                  rd_reason,
    output logic [TMR_W-1:0]            rd_elig,
    output logic [TMR_W-1:0]            rd_holdoff,
    output logic [TMR_W-1:0]            rd_cool,
    output logic [QL_W-1:0]             rd_ql,
    output logic [TEMP_W-1:0]           rd_temp,
    output logic [$clog2(DEPTH+1)-1:0]  fill_level,
    output logic                        wm_hit,
    output logic                        overflow,
    output logic                        rate_alarm
);
    localparam int REC_W = TS_W + 4 + 3 * TMR_W + QL_W + TEMP_W;

    sel_state_e   st_in;
    sel_reason_e  why_in;
    logic [REC_W-1:0] rec_in, rec_out;

    assign st_in  = sel_state_e'(sw_state);
    assign why_in = sel_reason_e'(sw_reason);
    assign rec_in = {ts_in, st_in, why_in, tmr_elig, tmr_holdoff, tmr_cool, ql_in, temp_in};

    sel_event_log_ring #(.DEPTH(DEPTH), .W(REC_W), .WM_LEVEL(WM_LEVEL)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sw_strobe),
        .wr_data  (rec_in),
        .rd_en    (rd_en),
        .rd_valid (rd_valid),
        .rd_data  (rec_out),
        .fill     (fill_level),
        .wm_hit   (wm_hit),
        .overflow (overflow)
    );

    sel_event_log_rate #(.WINDOW_CYC(WINDOW_CYC), .RATE_LIMIT(RATE_LIMIT)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (sw_strobe),
        .alarm  (rate_alarm)
    );

    assign {rd_ts, rd_state, rd_reason, rd_elig, rd_holdoff, rd_cool, rd_ql, rd_temp} = rec_out;

    p_log_on_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_strobe |=> rd_valid);
    p_quiet_no_growth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_strobe |=> (fill_level <= $past(fill_level)));
endmodule

// File: tb/sel_event_log_tb.sv
module sel_event_log_tb;
    typedef struct packed {
        logic [31:0] ts;
        logic [1:0]  st;
        logic [1:0]  rs;
        logic [15:0] el;
        logic [15:0] ho;
        logic [15:0] co;
        logic [3:0]  ql;
        logic [11:0] tp;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{32'h0000_1000, 2'd1, 2'd0, 16'h0010, 16'h0020, 16'h0030, 4'h3, 12'h1A0},
        '{32'h0000_1234, 2'd2, 2'd3, 16'hFFFF, 16'h0000, 16'h8001, 4'hF, 12'hFFF},
        '{32'h8000_0000, 2'd0, 2'd2, 16'h0001, 16'h7FFE, 16'h0000, 4'h0, 12'h000},
        '{32'hDEAD_BEEF, 2'd1, 2'd1, 16'hA5A5, 16'h5A5A, 16'h1234, 4'h9, 12'h555},
        '{32'hFFFF_FFFF, 2'd2, 2'd0, 16'h0000, 16'hFFFF, 16'hFFFF, 4'h1, 12'hAAA},
        '{32'h0000_0001, 2'd0, 2'd3, 16'h4321, 16'h0F0F, 16'hF0F0, 4'h7, 12'h321}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_strobe = 1'b0;
    logic [1:0]  sw_state = '0, sw_reason = '0;
    logic [15:0] tmr_elig = '0, tmr_holdoff = '0, tmr_cool = '0;
    logic [3:0]  ql_in = '0;
    logic [11:0] temp_in = '0;
    logic [31:0] ts_in = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_ts;
    logic [1:0]  rd_state, rd_reason;
    logic [15:0] rd_elig, rd_holdoff, rd_cool;
    logic [3:0]  rd_ql;
    logic [11:0] rd_temp;
    logic [5:0]  fill_level;
    logic        wm_hit, overflow, rate_alarm;

    int total = 0;
    int bad = 0;
    int tb_cyc = 0;
    bit done = 0;

    sel_event_log u_dut (
        .clk(clk), .rst_n(rst_n), .sw_strobe(sw_strobe), .sw_state(sw_state),
        .sw_reason(sw_reason), .tmr_elig(tmr_elig), .tmr_holdoff(tmr_holdoff),
        .tmr_cool(tmr_cool), .ql_in(ql_in), .temp_in(temp_in), .ts_in(ts_in),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_ts(rd_ts), .rd_state(rd_state),
        .rd_reason(rd_reason), .rd_elig(rd_elig), .rd_holdoff(rd_holdoff),
        .rd_cool(rd_cool), .rd_ql(rd_ql), .rd_temp(rd_temp),
        .fill_level(fill_level), .wm_hit(wm_hit), .overflow(overflow),
        .rate_alarm(rate_alarm)
    );

    always #5 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_cyc <= 0;
        else        tb_cyc <= tb_cyc + 1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sw_strobe = 1'b0;
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input vec_t v, input bit with_read);
        ts_in = v.ts; sw_state = v.st; sw_reason = v.rs;
        tmr_elig = v.el; tmr_holdoff = v.ho; tmr_cool = v.co;
        ql_in = v.ql; temp_in = v.tp;
        sw_strobe = 1'b1;
        rd_en = with_read;
        @(negedge clk);
        sw_strobe = 1'b0;
        rd_en = 1'b0;
        // scramble context inputs so the stored snapshot must not follow them
        tmr_elig = ~v.el; tmr_holdoff = ~v.ho; tmr_cool = ~v.co;
        ql_in = ~v.ql; temp_in = ~v.tp; ts_in = ~v.ts;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic vec_t tsv(input logic [31:0] t);
        vec_t v;
        v = '0;
        v.ts = t;
        return v;
    endfunction

    initial begin
        #(10 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 fill", fill_level, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 wm_hit", wm_hit, 0);
        chk("R1 rate_alarm", rate_alarm, 0);

        // table-driven record content
        for (int i = 0; i < 6; i++) begin
            push(VEC[i], 1'b0);
            chk("R2 fill grows", fill_level, i + 1);
        end
        for (int i = 0; i < 6; i++) begin
            chk("R5 rd_valid", rd_valid, 1);
            chk("R2 ts", rd_ts, VEC[i].ts);
            chk("R2 state", rd_state, VEC[i].st);
            chk("R2 reason", rd_reason, VEC[i].rs);
            chk("R3 elig", rd_elig, VEC[i].el);
            chk("R3 holdoff", rd_holdoff, VEC[i].ho);
            chk("R3 cool", rd_cool, VEC[i].co);
            chk("R4 ql", rd_ql, VEC[i].ql);
            chk("R4 temp", rd_temp, VEC[i].tp);
            pop();
        end
        chk("R5 drained", fill_level, 0);
        chk("R5 drained valid", rd_valid, 0);

        // empty read ignored, then strobe+read on empty store
        do_reset();
        pop();
        chk("R5 empty read fill", fill_level, 0);
        chk("R5 empty read valid", rd_valid, 0);
        push(tsv(32'd300), 1'b1);
        chk("R7 empty same-cycle fill", fill_level, 1);
        chk("R7 empty same-cycle ts", rd_ts, 300);

        // watermark and overflow
        do_reset();
        for (int i = 0; i < 33; i++) begin
            push(tsv(32'd100 + 32'(i)), 1'b0);
            if (i == 22) begin
                chk("R8 wm below", wm_hit, 0);
                chk("R8 fill 23", fill_level, 23);
            end
            if (i == 23) chk("R8 wm at", wm_hit, 1);
            if (i == 31) chk("R6 no ovf at 32", overflow, 0);
        end
        chk("R6 fill stays 32", fill_level, 32);
        chk("R6 overflow set", overflow, 1);
        chk("R6 oldest dropped", rd_ts, 101);
        pop();
        chk("R10 ovf after read", overflow, 1);
        chk("R6 next head", rd_ts, 102);
        chk("R6 fill 31", fill_level, 31);
        push(tsv(32'd200), 1'b0);
        chk("R6 refill 32", fill_level, 32);
        push(tsv(32'd201), 1'b1);
        chk("R7 full same-cycle fill", fill_level, 32);
        chk("R7 full same-cycle head", rd_ts, 103);
        for (int i = 0; i < 31; i++) pop();
        chk("R7 new record kept", rd_ts, 201);
        chk("R7 one left", fill_level, 1);
        chk("R10 ovf sticky", overflow, 1);
        chk("R8 wm low", wm_hit, 0);

        // rate window
        do_reset();
        while (tb_cyc % 256 != 20) @(negedge clk);
        for (int i = 0; i < 3; i++) push(tsv(32'(i)), 1'b0);
        chk("R9 at limit no alarm", rate_alarm, 0);
        push(tsv(32'd9), 1'b0);
        chk("R9 alarm on 4th", rate_alarm, 1);
        repeat (50) @(negedge clk);
        chk("R9 alarm holds", rate_alarm, 1);
        while (tb_cyc % 256 != 3) @(negedge clk);
        chk("R9 alarm cleared", rate_alarm, 0);
        for (int i = 0; i < 3; i++) push(tsv(32'(i)), 1'b0);
        chk("R9 count restarted", rate_alarm, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule